// File: doc/BRIEF.md
# Shared Frame Memory Access Arbiter

This block owns the single port of a processing element's unified memory, which holds instruction templates in one region and per-activation frame storage in the other. Two pipeline stages share that port. The match/frame stage reads a stored operand on a dyadic hit, writes the arriving operand on a dyadic miss, and reads constants. The output stage reads one or two destinations, or writes a sink result back to the frame. Each stage hands the block a single command when a token enters it. A per-stage sequencer expands the command into zero, one or two memory accesses and builds each address from a region bit, a frame number and a slot.

Only one access fits in a clock cycle. When both stages want the port, the output stage is served and the match/frame stage is stalled. A stalled request holds its address, direction and data until it is granted. The memory returns read data one cycle after the access, and the block routes it to the requester that was granted. A separate comparator checks an incoming token's (activation, slot) pair against the tokens that stages 3 to 5 still hold with a write pending. On a match it raises a hazard stall, so the dependent read waits until the earlier write has retired.

Top module: `fa_frame_arb`

## Requirements
- R1: Memory addresses are 9 bits, with the region bit on top (0 = instruction, 1 = frame). A frame address is {1, fid[1:0], slot[5:0]}. An instruction address is {0, offset[7:0]}, where the offset is formed as {fid, slot} from the port fields.
- R2: At most one access is issued per cycle. When both stages request, the output stage gets the grant, and the match stage sees m_stall_o=1 and m_gnt_o=0 for that cycle.
- R3: While a match stage request is stalled, its address, direction and write data stay unchanged, and it is served with those values once the output stage is idle.
- R4: In the cycle after a granted read, the granted stage's rvalid is 1 and its rdata carries the memory word. At all other times rvalid is 0.
- R5: Match command kinds are 0 = monadic, 1 = dyadic hit, 2 = dyadic miss, 3 = reserved (no access). A hit reads frame {1,fid,slot} and then, if m_const_i is set, reads the constant at {m_region_i, fid, cslot} in the next granted access.
- R6: A dyadic miss issues exactly one write of m_wdata_i to {1,fid,slot}. m_const_i is ignored for this kind.
- R7: A monadic command without a constant issues no access and pulses m_done_o in its start cycle. With a constant, it issues one constant read.
- R8: Output modes 0 and 1 read one destination at {o_region_i, fid, slot}. Modes 2 and 3 read two destinations, first slot and then slot+1 modulo 64, in consecutive cycles.
- R9: Output modes 4 and 5 issue no access, pulse o_done_o in their start cycle, and never stall the match stage.
- R10: Output modes 6 and 7 write o_wdata_i to {1,fid,slot}, one access.
- R11: Each stage's done pulse coincides with the grant of its last access. Its busy flag is cleared from the next cycle on, and no access is requested while both stages are idle.
- R12: haz_stall_o is 1 exactly when h_valid_i is set and some tracked stage entry is valid, has a pending write, and has the same activation id and slot as the incoming token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_start_i | input | 1 | Match stage command strobe, only while m_busy_o is 0 |
| m_kind_i | input | 2 | Match kind: 0 monadic, 1 hit, 2 miss, 3 reserved |
| m_const_i | input | 1 | Command needs a constant read |
| m_region_i | input | 1 | Region of the constant read |
| m_fid_i | input | 2 | Frame number |
| m_slot_i | input | 6 | Operand slot |
| m_cslot_i | input | 6 | Constant slot |
| m_wdata_i | input | 16 | Operand to store on a miss |
| m_gnt_o | output | 1 | Match access granted this cycle |
| m_stall_o | output | 1 | Match access pending but not granted |
| m_busy_o | output | 1 | Match sequencer has accesses left |
| m_done_o | output | 1 | Match command finished this cycle |
| m_rvalid_o | output | 1 | Match read data valid |
| m_rdata_o | output | 16 | Match read data |
| o_start_i | input | 1 | Output stage command strobe, only while o_busy_o is 0 |
| o_mode_i | input | 3 | Output mode 0 to 7 |
| o_region_i | input | 1 | Region of destination reads |
| o_fid_i | input | 2 | Frame number |
| o_slot_i | input | 6 | Destination or sink slot |
| o_wdata_i | input | 16 | Sink result |
| o_gnt_o | output | 1 | Output access granted this cycle |
| o_busy_o | output | 1 | Output sequencer has accesses left |
| o_done_o | output | 1 | Output command finished this cycle |
| o_rvalid_o | output | 1 | Output read data valid |
| o_rdata_o | output | 16 | Output read data |
| h_valid_i | input | 1 | Incoming token valid for the hazard check |
| h_act_i | input | 3 | Incoming activation id |
| h_slot_i | input | 6 | Incoming slot |
| s_valid_i | input | 3 | Stage entry valid, one bit per tracked stage |
| s_wr_i | input | 3 | Stage entry has a pending write |
| s_act_i | input | 9 | Stage activation ids, packed 3 bits per stage |
| s_slot_i | input | 18 | Stage slots, packed 6 bits per stage |
| haz_stall_o | output | 1 | Dependent token must wait |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 9 | Memory address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the read |

## Verification
Some properties are checked on every cycle. These are the output stage's priority under contention, the stability of a stalled match request, rvalid following each granted read, every write landing in the frame region, modes 4 and 5 never raising an output request, and busy dropping after a done pulse. Other behaviour can only be shown by the bench's scenarios, which compare the memory port against access lists built from the command encodings. These cover the exact addresses and their order, the slot wraparound on two-destination reads, a miss ignoring its constant flag, a later read returning data written by a sink, and the hazard comparator's response to matching and non-matching stage entries.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    MK_MONO = 2'd0,
    MK_HIT  = 2'd1,
    MK_MISS = 2'd2,
    MK_RSVD = 2'd3
  } mkind_e;

  localparam logic REG_INSTR = 1'b0;
  localparam logic REG_FRAME = 1'b1;

  function automatic logic [1:0] ms_count(mkind_e k, logic c);
    case (k)
      MK_HIT:  ms_count = c ? 2'd2 : 2'd1;
      MK_MISS: ms_count = 2'd1;
      MK_MONO: ms_count = c ? 2'd1 : 2'd0;
      default: ms_count = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] os_count(logic [2:0] mode);
    case (mode[2:1])
      2'b00:   os_count = 2'd1;
      2'b01:   os_count = 2'd2;
      2'b10:   os_count = 2'd0;
      default: os_count = 2'd1;
    endcase
  endfunction

  function automatic logic os_is_write(logic [2:0] mode);
    os_is_write = (mode[2:1] == 2'b11);
  endfunction
endpackage

// File: rtl/fa_ms_seq.sv
module fa_ms_seq
  import fa_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FID_W  = 2,
  parameter int SLOT_W = 6,
  localparam int AW    = 1 + FID_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mkind_e            kind_i,
  input  logic              const_i,
  input  logic              region_i,
  input  logic [FID_W-1:0]  fid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] cslot_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, idx_q;
  logic [1:0]        cnt_q;
  mkind_e            kind_q;
  logic              region_q;
  logic [FID_W-1:0]  fid_q;
  logic [SLOT_W-1:0] slot_q, cslot_q;
  logic [DW-1:0]     wdata_q;
  logic [1:0]        cnt_new;
  logic              accept, last, op_acc;

  assign cnt_new = ms_count(kind_i, const_i);
  assign accept  = start_i && !busy_q;
  assign last    = ({1'b0, idx_q} + 2'd1) == cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= MK_MONO;
      region_q <= 1'b0;
      fid_q    <= '0;
      slot_q   <= '0;
      cslot_q  <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      busy_q   <= (cnt_new != 2'd0);
      idx_q    <= 1'b0;
      cnt_q    <= cnt_new;
      kind_q   <= kind_i;
      region_q <= region_i;
      fid_q    <= fid_i;
      slot_q   <= slot_i;
      cslot_q  <= cslot_i;
      wdata_q  <= wdata_i;
    end else if (busy_q && gnt_i) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= 1'b1;
    end
  end

  // first access of hit/miss touches the operand slot, everything else is the constant
  assign op_acc  = !idx_q && (kind_q == MK_HIT || kind_q == MK_MISS);
  assign req_o   = busy_q;
  assign we_o    = busy_q && op_acc && (kind_q == MK_MISS);
  assign addr_o  = op_acc ? {REG_FRAME, fid_q, slot_q} : {region_q, fid_q, cslot_q};
  assign wdata_o = wdata_q;
  assign busy_o  = busy_q;
  assign done_o  = (accept && cnt_new == 2'd0) || (busy_q && gnt_i && last);
endmodule

// File: rtl/fa_os_seq.sv
module fa_os_seq
  import fa_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FID_W  = 2,
  parameter int SLOT_W = 6,
  localparam int AW    = 1 + FID_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic              region_i,
  input  logic [FID_W-1:0]  fid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, idx_q, wr_q, region_q;
  logic [1:0]        cnt_q;
  logic [FID_W-1:0]  fid_q;
  logic [SLOT_W-1:0] slot_q, rd_slot;
  logic [DW-1:0]     wdata_q;
  logic [1:0]        cnt_new;
  logic              accept, last;

  assign cnt_new = os_count(mode_i);
  assign accept  = start_i && !busy_q;
  assign last    = ({1'b0, idx_q} + 2'd1) == cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= 1'b0;
      wr_q     <= 1'b0;
      region_q <= 1'b0;
      cnt_q    <= '0;
      fid_q    <= '0;
      slot_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      busy_q   <= (cnt_new != 2'd0);
      idx_q    <= 1'b0;
      wr_q     <= os_is_write(mode_i);
      region_q <= region_i;
      cnt_q    <= cnt_new;
      fid_q    <= fid_i;
      slot_q   <= slot_i;
      wdata_q  <= wdata_i;
    end else if (busy_q && gnt_i) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= 1'b1;
    end
  end

  // second destination sits in the next slot, wrapping inside the frame
  assign rd_slot = slot_q + SLOT_W'(idx_q);
  assign req_o   = busy_q;
  assign we_o    = busy_q && wr_q;
  assign addr_o  = wr_q ? {REG_FRAME, fid_q, slot_q} : {region_q, fid_q, rd_slot};
  assign wdata_o = wdata_q;
  assign busy_o  = busy_q;
  assign done_o  = (accept && cnt_new == 2'd0) || (busy_q && gnt_i && last);
endmodule

// File: rtl/fa_hazard.sv
module fa_hazard #(
  parameter int ACT_W  = 3,
  parameter int SLOT_W = 6,
  parameter int NSTG   = 3
) (
  input  logic                     valid_i,
  input  logic [ACT_W-1:0]         act_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [NSTG-1:0]          s_valid_i,
  input  logic [NSTG-1:0]          s_wr_i,
  input  logic [NSTG*ACT_W-1:0]    s_act_i,
  input  logic [NSTG*SLOT_W-1:0]   s_slot_i,
  output logic                     stall_o
);
  logic [NSTG-1:0] hit;

  for (genvar g = 0; g < NSTG; g++) begin : g_cmp
    assign hit[g] = s_valid_i[g] && s_wr_i[g] &&
                    (s_act_i[g*ACT_W +: ACT_W] == act_i) &&
                    (s_slot_i[g*SLOT_W +: SLOT_W] == slot_i);
  end

  assign stall_o = valid_i && (|hit);
endmodule

// File: rtl/fa_frame_arb.sv
module fa_frame_arb
  import fa_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FID_W  = 2,
  parameter int SLOT_W = 6,
  parameter int ACT_W  = 3,
  parameter int NSTG   = 3,
  localparam int AW    = 1 + FID_W + SLOT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   m_start_i,
  input  logic [1:0]             m_kind_i,
  input  logic                   m_const_i,
  input  logic                   m_region_i,
  input  logic [FID_W-1:0]       m_fid_i,
  input  logic [SLOT_W-1:0]      m_slot_i,
  input  logic [SLOT_W-1:0]      m_cslot_i,
  input  logic [DW-1:0]          m_wdata_i,
  output logic                   m_gnt_o,
  output logic                   m_stall_o,
  output logic                   m_busy_o,
  output logic                   m_done_o,
  output logic                   m_rvalid_o,
  output logic [DW-1:0]          m_rdata_o,
  input  logic                   o_start_i,
  input  logic [2:0]             o_mode_i,
  input  logic                   o_region_i,
  input  logic [FID_W-1:0]       o_fid_i,
  input  logic [SLOT_W-1:0]      o_slot_i,
  input  logic [DW-1:0]          o_wdata_i,
  output logic                   o_gnt_o,
  output logic                   o_busy_o,
  output logic                   o_done_o,
  output logic                   o_rvalid_o,
  output logic [DW-1:0]          o_rdata_o,
  input  logic                   h_valid_i,
  input  logic [ACT_W-1:0]       h_act_i,
  input  logic [SLOT_W-1:0]      h_slot_i,
  input  logic [NSTG-1:0]        s_valid_i,
  input  logic [NSTG-1:0]        s_wr_i,
  input  logic [NSTG*ACT_W-1:0]  s_act_i,
  input  logic [NSTG*SLOT_W-1:0] s_slot_i,
  output logic                   haz_stall_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic [DW-1:0]          mem_rdata_i
);
  logic          m_req, m_we, o_req, o_we;
  logic [AW-1:0] m_addr, o_addr;
  logic [DW-1:0] m_wdata, o_wdata;
  logic          rd_m_q, rd_o_q;

  fa_ms_seq #(.DW(DW), .FID_W(FID_W), .SLOT_W(SLOT_W)) u_ms (
    .clk_i, .rst_ni,
    .start_i (m_start_i),
    .kind_i  (mkind_e'(m_kind_i)),
    .const_i (m_const_i),
    .region_i(m_region_i),
    .fid_i   (m_fid_i),
    .slot_i  (m_slot_i),
    .cslot_i (m_cslot_i),
    .wdata_i (m_wdata_i),
    .gnt_i   (m_gnt_o),
    .req_o   (m_req),
    .we_o    (m_we),
    .addr_o  (m_addr),
    .wdata_o (m_wdata),
    .busy_o  (m_busy_o),
    .done_o  (m_done_o)
  );

  fa_os_seq #(.DW(DW), .FID_W(FID_W), .SLOT_W(SLOT_W)) u_os (
    .clk_i, .rst_ni,
    .start_i (o_start_i),
    .mode_i  (o_mode_i),
    .region_i(o_region_i),
    .fid_i   (o_fid_i),
    .slot_i  (o_slot_i),
    .wdata_i (o_wdata_i),
    .gnt_i   (o_gnt_o),
    .req_o   (o_req),
    .we_o    (o_we),
    .addr_o  (o_addr),
    .wdata_o (o_wdata),
    .busy_o  (o_busy_o),
    .done_o  (o_done_o)
  );

  fa_hazard #(.ACT_W(ACT_W), .SLOT_W(SLOT_W), .NSTG(NSTG)) u_haz (
    .valid_i  (h_valid_i),
    .act_i    (h_act_i),
    .slot_i   (h_slot_i),
    .s_valid_i(s_valid_i),
    .s_wr_i   (s_wr_i),
    .s_act_i  (s_act_i),
    .s_slot_i (s_slot_i),
    .stall_o  (haz_stall_o)
  );

  // output stage has fixed priority on the single port
  assign o_gnt_o   = o_req;
  assign m_gnt_o   = m_req && !o_req;
  assign m_stall_o = m_req && o_req;

  assign mem_req_o   = o_req || m_req;
  assign mem_we_o    = o_req ? o_we    : m_we;
  assign mem_addr_o  = o_req ? o_addr  : m_addr;
  assign mem_wdata_o = o_req ? o_wdata : m_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_m_q <= 1'b0;
      rd_o_q <= 1'b0;
    end else begin
      rd_m_q <= m_gnt_o && !m_we;
      rd_o_q <= o_gnt_o && !o_we;
    end
  end

  assign m_rvalid_o = rd_m_q;
  assign o_rvalid_o = rd_o_q;
  assign m_rdata_o  = mem_rdata_i;
  assign o_rdata_o  = mem_rdata_i;
endmodule

// File: rtl/fa_frame_arb_chk.sv
module fa_frame_arb_chk #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          m_req,
  input logic          o_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          m_gnt_o,
  input logic          o_gnt_o,
  input logic          m_stall_o,
  input logic          m_busy_o,
  input logic          o_busy_o,
  input logic          m_done_o,
  input logic          o_done_o,
  input logic          m_rvalid_o,
  input logic          o_rvalid_o,
  input logic          o_start_i,
  input logic [2:0]    o_mode_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o
);
  // R2
  out_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req && o_req |-> o_gnt_o && !m_gnt_o && m_stall_o);

  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_stall_o |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

  // R4
  m_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_gnt_o && !mem_we_o |=> m_rvalid_o);

  // R4
  o_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_gnt_o && !mem_we_o |=> o_rvalid_o);

  // R9
  no_frame_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_start_i && !o_busy_o && (o_mode_i[2:1] == 2'b10) |=> !o_req);

  // R10
  write_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_addr_o[AW-1]);

  // R11
  m_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_done_o |=> !m_busy_o);

  // R11
  o_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_done_o |=> !o_busy_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_busy_o && !o_busy_o |-> !mem_req_o);
endmodule

bind fa_frame_arb fa_frame_arb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .m_req      (m_req),
  .o_req      (o_req),
  .m_we       (m_we),
  .m_addr     (m_addr),
  .m_wdata    (m_wdata),
  .m_gnt_o    (m_gnt_o),
  .o_gnt_o    (o_gnt_o),
  .m_stall_o  (m_stall_o),
  .m_busy_o   (m_busy_o),
  .o_busy_o   (o_busy_o),
  .m_done_o   (m_done_o),
  .o_done_o   (o_done_o),
  .m_rvalid_o (m_rvalid_o),
  .o_rvalid_o (o_rvalid_o),
  .o_start_i  (o_start_i),
  .o_mode_i   (o_mode_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/tb_fa_frame_arb.sv
module tb_fa_frame_arb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        m_start = 0, m_const = 0, m_region = 0;
  logic [1:0]  m_kind = 0, m_fid = 0;
  logic [5:0]  m_slot = 0, m_cslot = 0;
  logic [15:0] m_wdata = 0;
  logic        m_gnt, m_stall, m_busy, m_done, m_rvalid;
  logic [15:0] m_rdata;
  logic        o_start = 0, o_region = 0;
  logic [2:0]  o_mode = 0;
  logic [1:0]  o_fid = 0;
  logic [5:0]  o_slot = 0;
  logic [15:0] o_wdata = 0;
  logic        o_gnt, o_busy, o_done, o_rvalid;
  logic [15:0] o_rdata;
  logic        h_valid = 0;
  logic [2:0]  h_act = 0;
  logic [5:0]  h_slot = 0;
  logic [2:0]  s_valid = 0, s_wr = 0;
  logic [8:0]  s_act = 0;
  logic [17:0] s_slot = 0;
  logic        haz;
  logic        mem_req, mem_we;
  logic [8:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 0;

  fa_frame_arb dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .m_start_i(m_start), .m_kind_i(m_kind), .m_const_i(m_const), .m_region_i(m_region),
    .m_fid_i(m_fid), .m_slot_i(m_slot), .m_cslot_i(m_cslot), .m_wdata_i(m_wdata),
    .m_gnt_o(m_gnt), .m_stall_o(m_stall), .m_busy_o(m_busy), .m_done_o(m_done),
    .m_rvalid_o(m_rvalid), .m_rdata_o(m_rdata),
    .o_start_i(o_start), .o_mode_i(o_mode), .o_region_i(o_region), .o_fid_i(o_fid),
    .o_slot_i(o_slot), .o_wdata_i(o_wdata),
    .o_gnt_o(o_gnt), .o_busy_o(o_busy), .o_done_o(o_done), .o_rvalid_o(o_rvalid), .o_rdata_o(o_rdata),
    .h_valid_i(h_valid), .h_act_i(h_act), .h_slot_i(h_slot), .s_valid_i(s_valid), .s_wr_i(s_wr),
    .s_act_i(s_act), .s_slot_i(s_slot), .haz_stall_o(haz),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // memory model: one access per edge, read data registered
  logic [15:0] mem_arr [512];
  logic [15:0] shadow  [512];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_arr[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_arr[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] faddr(logic region, logic [1:0] fid, logic [5:0] slot);
    return {region, fid, slot};
  endfunction

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 37 + 5);
  endfunction

  // expected access lists
  logic [8:0]  em_addr [2];
  logic        em_we   [2];
  logic [15:0] em_data [2];
  int          mn;
  logic [8:0]  eo_addr [2];
  logic        eo_we   [2];
  logic [15:0] eo_data [2];
  int          on;

  task automatic build_lists(input bit do_m, input bit do_o);
    mn = 0; on = 0;
    if (do_m) begin
      case (m_kind)
        2'd1: begin
          em_addr[0] = faddr(1'b1, m_fid, m_slot); em_we[0] = 0; em_data[0] = 0; mn = 1;
          if (m_const) begin em_addr[1] = faddr(m_region, m_fid, m_cslot); em_we[1] = 0; em_data[1] = 0; mn = 2; end
        end
        2'd2: begin em_addr[0] = faddr(1'b1, m_fid, m_slot); em_we[0] = 1; em_data[0] = m_wdata; mn = 1; end
        2'd0: if (m_const) begin em_addr[0] = faddr(m_region, m_fid, m_cslot); em_we[0] = 0; em_data[0] = 0; mn = 1; end
        default: mn = 0;
      endcase
    end
    if (do_o) begin
      case (o_mode)
        3'd0, 3'd1: begin eo_addr[0] = faddr(o_region, o_fid, o_slot); eo_we[0] = 0; eo_data[0] = 0; on = 1; end
        3'd2, 3'd3: begin
          eo_addr[0] = faddr(o_region, o_fid, o_slot); eo_we[0] = 0; eo_data[0] = 0;
          eo_addr[1] = faddr(o_region, o_fid, o_slot + 6'd1); eo_we[1] = 0; eo_data[1] = 0; on = 2;
        end
        3'd6, 3'd7: begin eo_addr[0] = faddr(1'b1, o_fid, o_slot); eo_we[0] = 1; eo_data[0] = o_wdata; on = 1; end
        default: on = 0;
      endcase
    end
  endtask

  task automatic scenario(input bit do_m, input bit do_o);
    int mi, oi;
    bit pm, po, stalled;
    logic [15:0] pm_d, po_d;
    build_lists(do_m, do_o);
    @(negedge clk);
    m_start = do_m; o_start = do_o;
    #1;
    if (do_m && mn == 0) chk(m_done == 1'b1, "R7", m_done, 1);
    if (do_o && on == 0) chk(o_done == 1'b1, "R9", o_done, 1);
    @(negedge clk);
    m_start = 0; o_start = 0;
    mi = 0; oi = 0; pm = 0; po = 0; stalled = 0; pm_d = 0; po_d = 0;
    while (mi < mn || oi < on || pm || po) begin
      chk(m_rvalid == pm, "R4", m_rvalid, pm);
      if (pm) chk(m_rdata == pm_d, "R4", m_rdata, pm_d);
      chk(o_rvalid == po, "R4", o_rvalid, po);
      if (po) chk(o_rdata == po_d, "R4", o_rdata, po_d);
      pm = 0; po = 0;
      if (oi < on) begin
        chk(mem_req && o_gnt && !m_gnt, "R2", {mem_req, o_gnt, m_gnt}, 3'b110);
        chk(m_stall == (mi < mn), "R2", m_stall, (mi < mn));
        chk(mem_addr[8] == eo_addr[oi][8], "R1", mem_addr, eo_addr[oi]);
        chk(mem_addr == eo_addr[oi] && mem_we == eo_we[oi], eo_we[oi] ? "R10" : "R8",
            {mem_we, mem_addr}, {eo_we[oi], eo_addr[oi]});
        if (eo_we[oi]) chk(mem_wdata == eo_data[oi], "R10", mem_wdata, eo_data[oi]);
        chk(o_done == (oi == on - 1), "R11", o_done, (oi == on - 1));
        if (eo_we[oi]) shadow[eo_addr[oi]] = eo_data[oi];
        else begin po = 1; po_d = shadow[eo_addr[oi]]; end
        if (mi < mn) stalled = 1;
        oi++;
      end else if (mi < mn) begin
        chk(mem_req && m_gnt && !m_stall && !o_gnt, "R2", {mem_req, m_gnt, m_stall, o_gnt}, 4'b1100);
        chk(mem_addr[8] == em_addr[mi][8], "R1", mem_addr, em_addr[mi]);
        chk(mem_addr == em_addr[mi] && mem_we == em_we[mi], stalled ? "R3" : (em_we[mi] ? "R6" : "R5"),
            {mem_we, mem_addr}, {em_we[mi], em_addr[mi]});
        if (em_we[mi]) chk(mem_wdata == em_data[mi], "R6", mem_wdata, em_data[mi]);
        chk(m_done == (mi == mn - 1), "R11", m_done, (mi == mn - 1));
        if (em_we[mi]) shadow[em_addr[mi]] = em_data[mi];
        else begin pm = 1; pm_d = shadow[em_addr[mi]]; end
        mi++;
      end else begin
        chk(!mem_req, "R11", mem_req, 0);
      end
      @(negedge clk);
    end
    chk(!m_busy && !o_busy && !mem_req, "R11", {m_busy, o_busy, mem_req}, 0);
  endtask

  task automatic set_m(input logic [1:0] k, input logic c, input logic r, input logic [1:0] f,
                       input logic [5:0] s, input logic [5:0] cs, input logic [15:0] d);
    m_kind = k; m_const = c; m_region = r; m_fid = f; m_slot = s; m_cslot = cs; m_wdata = d;
  endtask

  task automatic set_o(input logic [2:0] md, input logic r, input logic [1:0] f,
                       input logic [5:0] s, input logic [15:0] d);
    o_mode = md; o_region = r; o_fid = f; o_slot = s; o_wdata = d;
  endtask

  function automatic bit haz_exp();
    bit h = 0;
    for (int g = 0; g < 3; g++)
      if (s_valid[g] && s_wr[g] && s_act[g*3 +: 3] == h_act && s_slot[g*6 +: 6] == h_slot) h = 1;
    return h_valid && h;
  endfunction

  task automatic haz_case(input string tag);
    #1;
    chk(haz == haz_exp(), tag, haz, haz_exp());
  endtask

  bit done_flag = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) begin mem_arr[i] = init_word(i); shadow[i] = init_word(i); end
    repeat (3) @(negedge clk);
    chk(!mem_req && !m_busy && !o_busy && !m_rvalid && !o_rvalid, "R11",
        {mem_req, m_busy, o_busy, m_rvalid, o_rvalid}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R7: monadic, no constant, alone
    set_m(2'd0, 0, 1, 2'd1, 6'd3, 6'd4, 16'h0); scenario(1, 0);
    // R7: monadic with instruction-region constant (R1)
    set_m(2'd0, 1, 0, 2'd2, 6'd5, 6'd17, 16'h0); scenario(1, 0);
    // R9: mode 4 beside a hit with constant: match never stalls
    set_m(2'd1, 1, 1, 2'd0, 6'd8, 6'd9, 16'h0); set_o(3'd4, 1, 2'd0, 6'd1, 16'h0); scenario(1, 1);
    // R2/R3/R8: mode 3 against hit+const, match waits two cycles
    set_m(2'd1, 1, 1, 2'd3, 6'd10, 6'd11, 16'h0); set_o(3'd3, 1, 2'd3, 6'd20, 16'h0); scenario(1, 1);
    // R6: miss with constant flag, single write
    set_m(2'd2, 1, 0, 2'd1, 6'd30, 6'd31, 16'hBEEF); scenario(1, 0);
    // R10/R4: sink write then hit read of the same slot returns new data
    set_m(2'd1, 0, 1, 2'd2, 6'd40, 6'd0, 16'h0); set_o(3'd7, 1, 2'd2, 6'd40, 16'hC0DE); scenario(1, 1);
    // R8: two destinations wrapping from slot 63 to 0
    set_o(3'd2, 1, 2'd1, 6'd63, 16'h0); scenario(0, 1);
    // R5: reserved kind does nothing
    set_m(2'd3, 1, 1, 2'd1, 6'd7, 6'd8, 16'h1234); scenario(1, 0);
    // R9: mode 5 alone
    set_o(3'd5, 0, 2'd0, 6'd2, 16'h0); scenario(0, 1);

    for (int it = 0; it < 400; it++) begin
      bit dm = 1'($urandom), dn = 1'($urandom);
      set_m(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 6'($urandom), 6'($urandom), 16'($urandom));
      set_o(3'($urandom), 1'($urandom), 2'($urandom), 6'($urandom), 16'($urandom));
      scenario(dm, dn);
    end

    // R12 directed hazard cases
    h_valid = 1; h_act = 3'd5; h_slot = 6'd9;
    s_valid = 3'b010; s_wr = 3'b010; s_act = {3'd0, 3'd5, 3'd0}; s_slot = {6'd0, 6'd9, 6'd0};
    haz_case("R12");
    chk(haz == 1'b1, "R12", haz, 1);
    s_slot = {6'd0, 6'd8, 6'd0}; haz_case("R12");
    s_slot = {6'd0, 6'd9, 6'd0}; s_wr = 3'b000; haz_case("R12");
    s_wr = 3'b010; h_valid = 0; haz_case("R12");
    h_valid = 1; s_act = {3'd0, 3'd4, 3'd0}; haz_case("R12");
    s_valid = 3'b100; s_wr = 3'b100; s_act = {3'd5, 3'd0, 3'd0}; s_slot = {6'd9, 6'd0, 6'd0}; haz_case("R12");
    for (int it = 0; it < 300; it++) begin
      h_valid = 1'($urandom); h_act = 3'($urandom % 2); h_slot = 6'($urandom % 3);
      s_valid = 3'($urandom); s_wr = 3'($urandom);
      for (int g = 0; g < 3; g++) begin
        s_act[g*3 +: 3] = 3'($urandom % 2);
        s_slot[g*6 +: 6] = 6'($urandom % 3);
      end
      haz_case("R12");
    end

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule